// File: doc/BRIEF.md
# Dual-Lane Reloading Pulse Generator

The block makes rectangular waveforms from two 8-bit down-counters. Each lane keeps two reload values, one for the width of the low phase and one for the width of the high phase. The phase output toggles every time the running count reaches zero. The counter then reloads from the register of the phase that is about to begin. A width value N gives a phase of N+1 count ticks. The count tick is picked by a select field. It can be the system clock undivided, the clock divided by 2, 4, 8 or 16, or a slow tick pulse supplied by the oscillator domain.

The two lanes can be arranged in three ways. In split mode they run as two independent 8-bit generators, each driving its own pin. In wide mode they form one 16-bit counter whose widths are the concatenated register pairs. In prescale mode lane 0 divides the tick and lane 1 generates the waveform from that divided tick. A sticky interrupt flag per pin is raised whenever a high phase ends. It is cleared by a clear strobe. No data stream passes through the block, so all pins are plain control and status signals without valid/ready handshakes.

Top module: `pulse_pair_gen`

## Requirements
- R1: After reset both pulse outputs and both interrupt flags are 0.
- R2: In split mode (mode 0 or 3), each lane runs on its own enable. Register address 0 is lane 0 low width, 1 is lane 0 high width, 2 is lane 1 low width and 3 is lane 1 high width. A lane's pin starts low when the lane is enabled. The low phase lasts low+1 ticks and the high phase lasts high+1 ticks.
- R3: Clock select 0 gives a tick on every cycle. Select k from 1 to 4 gives one tick every 2^k cycles. Select 5 uses slow_tick_i pulses. Selects 6 and 7 give no ticks, so the pins stay low.
- R4: A reload register write does not change the phase in progress. It takes effect at the next reload from that register.
- R5: In wide mode (mode 1), enable_i[1] runs the pair. The low phase lasts {reg2,reg0}+1 ticks and the high phase lasts {reg3,reg1}+1 ticks. Both appear on pulse_o[1], and pulse_o[0] stays low.
- R6: In prescale mode (mode 2), enable_i[1] runs the pair. Lane 0 reloads continuously from reg0, and its zero count gives one tick to lane 1. The low phase of pulse_o[1] lasts (reg2+1)*(reg0+1) ticks and the high phase lasts (reg3+1)*(reg0+1) ticks. Register 1 is unused and pulse_o[0] stays low.
- R7: irq_o[i] is set in the cycle where pin i's high phase ends. The end of a low phase does not set it.
- R8: irq_clr_i[i] clears irq_o[i] on the next edge. When a set and a clear fall in the same cycle, the set wins.
- R9: Dropping the enable drives the pin low on the next edge and stops counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Reload register write strobe |
| wr_addr_i | input | 2 | Reload register select |
| wr_data_i | input | 8 | Reload value |
| mode_i | input | 2 | 0/3 split, 1 wide, 2 prescale |
| clk_sel_i | input | 3 | Count tick select |
| enable_i | input | 2 | Lane enables |
| slow_tick_i | input | 1 | Slow tick pulse from the oscillator domain |
| irq_clr_i | input | 2 | Interrupt flag clear strobes |
| pulse_o | output | 2 | Waveform pins |
| irq_o | output | 2 | Sticky high-phase-end flags |

## Verification
The colliding pair is the end of a high phase, which sets the interrupt flag, and a software clear of that same flag. The bench holds irq_clr_i[1] asserted across a falling edge of pulse_o[1]. It then expects the flag to read 1 in the cycle after the fall and 0 one cycle later. A second collision is a reload register write landing inside the phase that register governs. That case is judged by measuring the current phase width and then the next one.

// File: rtl/ppg_pkg.sv
package ppg_pkg;
  typedef enum logic [1:0] {
    MODE_SPLIT    = 2'd0,
    MODE_WIDE     = 2'd1,
    MODE_PRESCALE = 2'd2,
    MODE_SPLIT_B  = 2'd3
  } ppg_mode_e;
endpackage

// File: rtl/ppg_tick.sv
module ppg_tick #(
  parameter int SEL_W      = 3,
  parameter int DIV_STAGES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             slow_tick_i,
  output logic             tick_o
);
  localparam int SLOW_SEL = DIV_STAGES + 1;

  logic [DIV_STAGES-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end

  // Power-of-two divide: tick when the low k bits are all ones.
  always_comb begin
    tick_o = 1'b0;
    for (int k = 0; k <= DIV_STAGES; k++) begin
      if (sel_i == SEL_W'(k))
        tick_o = &(div_q | ~DIV_STAGES'((1 << k) - 1));
    end
    if (sel_i == SEL_W'(SLOW_SEL)) tick_o = slow_tick_i;
  end

  AST_DIV_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && sel_i != '0 && sel_i <= SEL_W'(DIV_STAGES))
      |=> (!tick_o || sel_i != $past(sel_i))); // R3
endmodule

// File: rtl/ppg_lane.sv
module ppg_lane #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_i,
  input  logic [CW-1:0] ld_val_i,
  input  logic          dec_i,
  output logic [CW-1:0] cnt_o,
  output logic          zero_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_o <= '0;
    else if (ld_i)  cnt_o <= ld_val_i;
    else if (dec_i) cnt_o <= cnt_o - 1'b1;
  end

  assign zero_o = (cnt_o == '0);

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    ld_i |=> (cnt_o == $past(ld_val_i))); // R4

  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && !ld_i) |=> (cnt_o == $past(cnt_o) - 1'b1)); // R2
endmodule

// File: rtl/pulse_pair_gen.sv
module pulse_pair_gen
  import ppg_pkg::*;
#(
  parameter int CW         = 8,
  parameter int SEL_W      = 3,
  parameter int DIV_STAGES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [CW-1:0]    wr_data_i,
  input  logic [1:0]       mode_i,
  input  logic [SEL_W-1:0] clk_sel_i,
  input  logic [1:0]       enable_i,
  input  logic             slow_tick_i,
  input  logic [1:0]       irq_clr_i,
  output logic [1:0]       pulse_o,
  output logic [1:0]       irq_o
);
  localparam int LANES = 2;

  logic [CW-1:0] lo_q [LANES];
  logic [CW-1:0] hi_q [LANES];
  logic [CW-1:0] cnt  [LANES];
  logic [CW-1:0] ldv  [LANES];
  logic [LANES-1:0] ld, dec, zero, uf, act, ph_q, irq_q, set;
  logic tick, pre_uf, split, lane0_run;
  ppg_mode_e mode;

  assign mode  = ppg_mode_e'(mode_i);
  assign split = (mode != MODE_WIDE) && (mode != MODE_PRESCALE);

  ppg_tick #(.SEL_W(SEL_W), .DIV_STAGES(DIV_STAGES)) u_tick (
    .clk(clk), .rst_n(rst_n), .sel_i(clk_sel_i),
    .slow_tick_i(slow_tick_i), .tick_o(tick)
  );

  // Reload registers: address bit 1 picks the lane, bit 0 picks high width.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LANES; i++) begin
        lo_q[i] <= '0;
        hi_q[i] <= '0;
      end
    end else if (wr_en_i) begin
      if (wr_addr_i[0]) hi_q[wr_addr_i[1]] <= wr_data_i;
      else              lo_q[wr_addr_i[1]] <= wr_data_i;
    end
  end

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      ppg_lane #(.CW(CW)) u_lane (
        .clk(clk), .rst_n(rst_n), .ld_i(ld[g]), .ld_val_i(ldv[g]),
        .dec_i(dec[g]), .cnt_o(cnt[g]), .zero_o(zero[g])
      );
    end
  endgenerate

  assign act[0]    = split ? enable_i[0] : enable_i[1];
  assign act[1]    = enable_i[1];
  assign lane0_run = split && enable_i[0];

  always_comb begin
    ld     = '0;
    dec    = '0;
    uf     = '0;
    pre_uf = 1'b0;
    for (int i = 0; i < LANES; i++) ldv[i] = lo_q[i];
    case (mode)
      MODE_WIDE: begin
        uf[1]  = act[1] && tick && zero[0] && zero[1];
        ld[0]  = !act[1] || uf[1];
        ld[1]  = ld[0];
        for (int i = 0; i < LANES; i++)
          ldv[i] = (!act[1] || ph_q[1]) ? lo_q[i] : hi_q[i];
        dec[0] = act[1] && tick && !(zero[0] && zero[1]);
        dec[1] = act[1] && tick && zero[0] && !zero[1];
      end
      MODE_PRESCALE: begin
        pre_uf = act[1] && tick && zero[0];
        ld[0]  = !act[1] || pre_uf;
        ldv[0] = lo_q[0];
        dec[0] = act[1] && tick && !zero[0];
        uf[1]  = pre_uf && zero[1];
        ld[1]  = !act[1] || uf[1];
        ldv[1] = (!act[1] || ph_q[1]) ? lo_q[1] : hi_q[1];
        dec[1] = pre_uf && !zero[1];
      end
      default: begin
        for (int i = 0; i < LANES; i++) begin
          uf[i]  = act[i] && tick && zero[i];
          ld[i]  = !act[i] || uf[i];
          ldv[i] = (!act[i] || ph_q[i]) ? lo_q[i] : hi_q[i];
          dec[i] = act[i] && tick && !zero[i];
        end
      end
    endcase
  end

  assign set = uf & ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= '0;
      irq_q <= '0;
    end else begin
      if (!lane0_run)  ph_q[0] <= 1'b0;
      else if (uf[0])  ph_q[0] <= ~ph_q[0];
      if (!act[1])     ph_q[1] <= 1'b0;
      else if (uf[1])  ph_q[1] <= ~ph_q[1];
      irq_q <= set | (irq_q & ~irq_clr_i);
    end
  end

  assign pulse_o = ph_q;
  assign irq_o   = irq_q;

  AST_IRQ_ON_HIGH_END: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ph_q[1]) && $past(enable_i[1])) |-> irq_q[1]); // R7

  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr_i[1] && !set[1]) |=> !irq_q[1]); // R8

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set[1] |=> irq_q[1]); // R8

  AST_DISABLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i[1] |=> !pulse_o[1]); // R9

  AST_PIN0_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !split |=> !pulse_o[0]); // R5

  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_i[1] && !uf[1]) |=> $stable(ph_q[1])); // R2
endmodule

// File: tb/sim_pulse_pair_gen.sv
module sim_pulse_pair_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] mode = '0;
  logic [2:0] sel = '0;
  logic [1:0] en = '0;
  logic       slow = 1'b0;
  logic [1:0] clr = '0;
  logic [1:0] pulse, irq;
  int checks = 0, errors = 0;
  int p0_cnt = 0, p1_cnt = 0;

  always #4 clk = ~clk;

  pulse_pair_gen u0 (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .mode_i(mode), .clk_sel_i(sel), .enable_i(en),
    .slow_tick_i(slow), .irq_clr_i(clr), .pulse_o(pulse), .irq_o(irq)
  );

  // Slow tick: one cycle high every five cycles.
  initial forever begin
    repeat (4) @(negedge clk);
    slow = 1'b1;
    @(negedge clk);
    slow = 1'b0;
  end

  always @(negedge clk) begin
    if (pulse[0]) p0_cnt++;
    if (pulse[1]) p1_cnt++;
  end

  typedef struct packed {
    int md; int sl; int lo0; int hi0; int lo1; int hi1;
    int e1lo; int e1hi; int e0lo; int e0hi;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{0, 0,   3,   5,   2,   7,   3,   8,   4,   6},
    '{0, 2,   1,   0,   0,   2,   4,  12,   8,   4},
    '{0, 5,   0,   1,   1,   0,  10,   5,   5,  10},
    '{1, 0,   4,   2,   1,   0, 261,   3,   0,   0},
    '{1, 1,   0,   0,   0,   1,   2, 514,   0,   0},
    '{2, 0,   2,   9,   1,   3,   6,  12,   0,   0},
    '{2, 3,   0,   5,   0,   0,   8,   8,   0,   0},
    '{0, 4,   0,   0,   0,   0,  16,  16,  16,  16},
    '{0, 0,   0, 255, 255,   0, 256,   1,   1, 256}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    wr_addr = 2'(a);
    wr_data = 8'(d);
    wr_en   = 1'b1;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  // Measures one full high phase and the following low phase on a pin.
  task automatic measure(input int pin, output int lo, output int hi);
    while (pulse[pin]) @(negedge clk);
    while (!pulse[pin]) @(negedge clk);
    hi = 0;
    while (pulse[pin]) begin hi++; @(negedge clk); end
    lo = 0;
    while (!pulse[pin]) begin lo++; @(negedge clk); end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1..R9 run actual=hung expected=done");
    finish_run();
  end

  initial begin
    int lo, hi, snap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pulse after reset", int'(pulse), 0);
    chk("R1 irq after reset", int'(irq), 0);

    // Table walk: R2 split, R3 tick select, R5 wide, R6 prescale.
    foreach (VEC[i]) begin
      en = '0;
      repeat (2) @(negedge clk);
      mode = 2'(VEC[i].md);
      sel  = 3'(VEC[i].sl);
      wr(0, VEC[i].lo0);
      wr(1, VEC[i].hi0);
      wr(2, VEC[i].lo1);
      wr(3, VEC[i].hi1);
      snap = p0_cnt;
      en = (VEC[i].md == 0) ? 2'b11 : 2'b10;
      measure(1, lo, hi);
      chk($sformatf("R2/R3/R5/R6 vec%0d pin1 low", i), lo, VEC[i].e1lo);
      chk($sformatf("R2/R3/R5/R6 vec%0d pin1 high", i), hi, VEC[i].e1hi);
      if (VEC[i].md == 0) begin
        measure(0, lo, hi);
        chk($sformatf("R2 vec%0d pin0 low", i), lo, VEC[i].e0lo);
        chk($sformatf("R2 vec%0d pin0 high", i), hi, VEC[i].e0hi);
      end else begin
        chk($sformatf("R5 R6 vec%0d pin0 quiet", i), p0_cnt - snap, 0);
      end
    end

    // R3: select 6 produces no ticks.
    en = '0;
    repeat (2) @(negedge clk);
    mode = 2'd0; sel = 3'd6;
    wr(2, 0); wr(3, 0);
    snap = p1_cnt;
    en = 2'b10;
    repeat (40) @(negedge clk);
    chk("R3 select 6 idle", p1_cnt - snap, 0);

    // R4: a write during the high phase affects only the next high phase.
    en = '0;
    repeat (2) @(negedge clk);
    sel = 3'd0;
    wr(2, 3); wr(3, 3);
    en = 2'b10;
    while (pulse[1]) @(negedge clk);
    while (!pulse[1]) @(negedge clk);
    wr_addr = 2'd3; wr_data = 8'd9; wr_en = 1'b1;
    hi = 0;
    while (pulse[1]) begin hi++; @(negedge clk); wr_en = 1'b0; end
    chk("R4 current high unchanged", hi, 4);
    lo = 0;
    while (!pulse[1]) begin lo++; @(negedge clk); end
    chk("R4 low unchanged", lo, 4);
    hi = 0;
    while (pulse[1]) begin hi++; @(negedge clk); end
    chk("R4 next high uses new value", hi, 10);

    // R7/R8: interrupt flag set, clear and collision.
    en = '0;
    repeat (2) @(negedge clk);
    wr(0, 1); wr(1, 1); wr(2, 3); wr(3, 3);
    clr = 2'b11;
    @(negedge clk);
    clr = 2'b00;
    chk("R8 cleared before start", int'(irq), 0);
    en = 2'b11;
    while (!pulse[1]) @(negedge clk);
    chk("R7 no irq at low end", int'(irq[1]), 0);
    while (pulse[1]) @(negedge clk);
    chk("R7 irq at high end", int'(irq[1]), 1);
    chk("R7 irq lane0 split", int'(irq[0]), 1);
    clr[1] = 1'b1;
    @(negedge clk);
    chk("R8 clear", int'(irq[1]), 0);
    while (!pulse[1]) @(negedge clk);
    while (pulse[1]) @(negedge clk);
    chk("R8 set wins over clear", int'(irq[1]), 1);
    @(negedge clk);
    chk("R8 clear after collision", int'(irq[1]), 0);
    clr = '0;

    // R9: disable during a high phase.
    while (!pulse[1]) @(negedge clk);
    en = '0;
    @(negedge clk);
    chk("R9 low after disable", int'(pulse[1]), 0);
    snap = p1_cnt;
    repeat (20) @(negedge clk);
    chk("R9 stays low", p1_cnt - snap, 0);

    finish_run();
  end
endmodule